// File: doc/BRIEF.md
# Single-Clock FIFO with Compile-Time Read Mode

This block is a first-in first-out buffer that runs on one clock. Words go in through a write enable and a data input, and come out through a read enable and a data output. A compile-time parameter picks one of two read modes. In the standard mode the word for an accepted read comes out on the clock after the request and is held until the next accepted read. In the fall-through mode the oldest stored word is on the output whenever the buffer holds anything, and a read enable pops it so that the next word appears.

Around the storage the block drives full and empty flags, one-step-early warnings (almost full and almost empty), two level flags with thresholds set by parameter, an occupancy count, a read-valid output, and single-cycle overflow and underflow strobes for requests that could not be served. Storage is a plain register array with a power-of-two depth. Each read and write pointer carries one extra wrap bit, so the occupancy is the difference of the two pointers. A synchronous active-high reset empties the buffer.

Top module: `fifo_rdmode`

## Requirements
- R1: In standard mode (MODE = 0), a read enable seen while the buffer is not empty is accepted, and the oldest word appears on rd_data at the next rising edge. rd_data then holds that word until the next accepted read.
- R2: In standard mode, rd_valid is high for exactly the one cycle after each accepted read and low in every other cycle.
- R3: In fall-through mode (MODE = 1), rd_valid equals not-empty, and rd_data shows the oldest stored word whenever rd_valid is high. A word written into an empty buffer is shown after the edge that stores it, and an accepted read replaces the shown word with the next one after that edge.
- R4: A write enable seen while full is true is discarded, even when a read is accepted in the same cycle. overflow is high for exactly the one cycle after that request.
- R5: A read enable seen while empty is true changes no stored state and no output data. underflow is high for exactly the one cycle after that request.
- R6: full is high exactly when the count equals DEPTH (16 by default). empty is high exactly when the count is 0.
- R7: almost_full is high exactly when the count equals DEPTH-1. almost_empty is high exactly when the count equals 1.
- R8: prog_full is high when the count is at least PFULL_LVL (default DEPTH/2 = 8). prog_empty is high when the count is at most PEMPTY_LVL (default 2).
- R9: level reports the number of stored words. An accepted read and an accepted write in the same cycle leave it unchanged.
- R10: While rst is high at a rising edge, the buffer is emptied: level becomes 0, empty and prog_empty go high, every other flag and strobe goes low, and in standard mode rd_data becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request (pop in fall-through mode) |
| rd_data | output | DATA_W | Read word |
| rd_valid | output | 1 | rd_data carries a word (meaning depends on MODE) |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | Buffer holds no words |
| almost_full | output | 1 | One more write fills the buffer |
| almost_empty | output | 1 | One more read empties the buffer |
| prog_full | output | 1 | Count at or above PFULL_LVL |
| prog_empty | output | 1 | Count at or below PEMPTY_LVL |
| overflow | output | 1 | Strobe: a write was refused in the previous cycle |
| underflow | output | 1 | Strobe: a read was refused in the previous cycle |
| level | output | ADDR_W+1 | Number of stored words |

## Verification
Both read modes are built side by side and get identical stimulus, so a data or valid fault shows up as a divergence from a queue model. A fill past full and a drain past empty step the count through every value and separate each flag threshold from its neighbours. They also separate refused requests from accepted ones, including read-plus-write at full and at empty. Long runs of reads and writes in the same cycle at mid occupancy show whether the count stays put and whether the pointers wrap correctly. A pseudo-random mix and a reset in mid run then check ordering under arbitrary interleaving and show that reset really empties the buffer.

// File: rtl/fifo_rdmode_pkg.sv
package fifo_rdmode_pkg;

   typedef enum logic {
      RD_STANDARD = 1'b0,
      RD_FALLTHRU = 1'b1
   } rd_mode_e;

   typedef struct packed {
      logic full;
      logic empty;
      logic afull;
      logic aempty;
      logic pfull;
      logic pempty;
   } lvl_flags_t;

endpackage

// File: rtl/fifo_rdmode_ctrl.sv
module fifo_rdmode_ctrl #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic              wr_acc,
   output logic              rd_acc,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [ADDR_W:0]   level,
   output logic              overflow,
   output logic              underflow
);
   localparam int PTR_W = ADDR_W + 1;
   localparam logic [PTR_W-1:0] DEPTH_V = PTR_W'(1 << ADDR_W);

   logic [PTR_W-1:0] wptr_q;
   logic [PTR_W-1:0] rptr_q;
   logic             is_full;
   logic             is_empty;

   assign level    = wptr_q - rptr_q;
   assign is_full  = (level == DEPTH_V);
   assign is_empty = (level == '0);
   assign wr_acc   = wr_en && !is_full;
   assign rd_acc   = rd_en && !is_empty;
   assign wr_addr  = wptr_q[ADDR_W-1:0];
   assign rd_addr  = rptr_q[ADDR_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr_q    <= '0;
         rptr_q    <= '0;
         overflow  <= 1'b0;
         underflow <= 1'b0;
      end else begin
         if (wr_acc) wptr_q <= wptr_q + 1'b1;
         if (rd_acc) rptr_q <= rptr_q + 1'b1;
         overflow  <= wr_en && is_full;
         underflow <= rd_en && is_empty;
      end
   end

   // R6: the pointer difference never exceeds the depth
   assert_level_bound_R6: assert property (@(posedge clk) disable iff (rst)
      level <= DEPTH_V);

   // R4: a refused write never raises the count
   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && is_full) |=> (level <= $past(level)));

   // R5: a read on an empty buffer leaves the read pointer alone
   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
      (rd_en && is_empty) |=> $stable(rptr_q));

   // R9: matched read and write keep occupancy steady
   assert_rw_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (wr_en && rd_en && !is_full && !is_empty) |=> $stable(level));

endmodule

// File: rtl/fifo_rdmode_store.sv
module fifo_rdmode_store #(
   parameter int DATA_W = 18,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              wr_acc,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] head_word
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      always_ff @(posedge clk) begin
         if (wr_acc && (wr_addr == ADDR_W'(g))) cells[g] <= wr_data;
      end
   end

   assign head_word = cells[rd_addr];

endmodule

// File: rtl/fifo_rdmode_levels.sv
module fifo_rdmode_levels
   import fifo_rdmode_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int PFULL_LVL  = 8,
   parameter int PEMPTY_LVL = 2
) (
   input  logic [ADDR_W:0] level,
   output lvl_flags_t      flags
);
   localparam int PTR_W = ADDR_W + 1;
   localparam logic [PTR_W-1:0] DEPTH_V = PTR_W'(1 << ADDR_W);
   localparam logic [PTR_W-1:0] PF_V    = PTR_W'(PFULL_LVL);
   localparam logic [PTR_W-1:0] PE_V    = PTR_W'(PEMPTY_LVL);

   always_comb begin
      flags.full   = (level == DEPTH_V);
      flags.empty  = (level == '0);
      flags.afull  = (level == DEPTH_V - 1'b1);
      flags.aempty = (level == PTR_W'(1));
      flags.pfull  = (level >= PF_V);
      flags.pempty = (level <= PE_V);
   end

endmodule

// File: rtl/fifo_rdmode_rdout.sv
module fifo_rdmode_rdout
   import fifo_rdmode_pkg::*;
#(
   parameter int       DATA_W = 18,
   parameter int       ADDR_W = 4,
   parameter rd_mode_e MODE   = RD_STANDARD
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_acc,
   input  logic [ADDR_W:0]   level,
   input  logic [DATA_W-1:0] head_word,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   if (MODE == RD_STANDARD) begin : g_std
      logic [DATA_W-1:0] data_q;
      logic              vld_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            data_q <= '0;
            vld_q  <= 1'b0;
         end else begin
            vld_q <= rd_acc;
            if (rd_acc) data_q <= head_word;
         end
      end

      assign rd_data  = data_q;
      assign rd_valid = vld_q;

      // R1: a read is only accepted from stored data
      assert_std_src_R1: assert property (@(posedge clk) disable iff (rst)
         rd_acc |-> (level != '0));

      // R1: output word is held between accepted reads
      assert_std_hold_R1: assert property (@(posedge clk) disable iff (rst)
         !rd_acc |=> $stable(rd_data));
   end else begin : g_fwft
      assign rd_data  = head_word;
      assign rd_valid = (level != '0);

      // R3: a pop only happens while a word is being shown
      assert_fwft_pop_R3: assert property (@(posedge clk) disable iff (rst)
         rd_acc |-> rd_valid);
   end

endmodule

// File: rtl/fifo_rdmode.sv
module fifo_rdmode
   import fifo_rdmode_pkg::*;
#(
   parameter int       DATA_W     = 18,
   parameter int       ADDR_W     = 4,
   parameter rd_mode_e MODE       = RD_STANDARD,
   parameter int       PFULL_LVL  = (1 << ADDR_W) / 2,
   parameter int       PEMPTY_LVL = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              full,
   output logic              empty,
   output logic              almost_full,
   output logic              almost_empty,
   output logic              prog_full,
   output logic              prog_empty,
   output logic              overflow,
   output logic              underflow,
   output logic [ADDR_W:0]   level
);
   localparam int DEPTH = 1 << ADDR_W;

   if (DATA_W < 1) begin : g_bad_width
      $error("fifo_rdmode: DATA_W must be at least 1");
   end
   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
      $error("fifo_rdmode: ADDR_W must lie in 2..12");
   end
   if (PFULL_LVL < 1 || PFULL_LVL > DEPTH) begin : g_bad_pf
      $error("fifo_rdmode: PFULL_LVL must lie in 1..DEPTH");
   end
   if (PEMPTY_LVL < 0 || PEMPTY_LVL >= DEPTH) begin : g_bad_pe
      $error("fifo_rdmode: PEMPTY_LVL must lie in 0..DEPTH-1");
   end

   logic              wr_acc;
   logic              rd_acc;
   logic [ADDR_W-1:0] wr_addr;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] head_word;
   lvl_flags_t        flags;

   fifo_rdmode_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .wr_acc    (wr_acc),
      .rd_acc    (rd_acc),
      .wr_addr   (wr_addr),
      .rd_addr   (rd_addr),
      .level     (level),
      .overflow  (overflow),
      .underflow (underflow)
   );

   fifo_rdmode_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
      .clk       (clk),
      .wr_acc    (wr_acc),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .head_word (head_word)
   );

   fifo_rdmode_levels #(
      .ADDR_W     (ADDR_W),
      .PFULL_LVL  (PFULL_LVL),
      .PEMPTY_LVL (PEMPTY_LVL)
   ) u_levels (
      .level (level),
      .flags (flags)
   );

   fifo_rdmode_rdout #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE(MODE)) u_rdout (
      .clk       (clk),
      .rst       (rst),
      .rd_acc    (rd_acc),
      .level     (level),
      .head_word (head_word),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid)
   );

   assign full         = flags.full;
   assign empty        = flags.empty;
   assign almost_full  = flags.afull;
   assign almost_empty = flags.aempty;
   assign prog_full    = flags.pfull;
   assign prog_empty   = flags.pempty;

   // R7: the four boundary flags never overlap
   assert_flag_excl_R7: assert property (@(posedge clk) disable iff (rst)
      $onehot0({full, almost_full, empty, almost_empty}));

   // R5: a refused read is followed by an underflow strobe
   assert_udf_strobe_R5: assert property (@(posedge clk) disable iff (rst)
      (rd_en && empty) |=> underflow);

   // R4: a refused write is followed by an overflow strobe
   assert_ovf_strobe_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && full) |=> overflow);

   // R8: programmable full implies not empty
   assert_pfull_R8: assert property (@(posedge clk) disable iff (rst)
      prog_full |-> !empty);

   if (MODE == RD_STANDARD) begin : g_std_chk
      // R2: accepted read gives a valid strobe next cycle
      assert_std_valid_R2: assert property (@(posedge clk) disable iff (rst)
         (rd_en && !empty) |=> rd_valid);
      // R2: no read, no valid
      assert_std_novalid_R2: assert property (@(posedge clk) disable iff (rst)
         (!rd_en || empty) |=> !rd_valid);
   end else begin : g_fwft_chk
      // R3: a word is shown whenever data is stored
      assert_fwft_valid_R3: assert property (@(posedge clk) disable iff (rst)
         rd_valid == !empty);
   end

endmodule

// File: tb/fifo_rdmode_bench.sv
`timescale 1ns / 1ps
module fifo_rdmode_bench;
   import fifo_rdmode_pkg::*;

   localparam int DW    = 18;
   localparam int AW    = 4;
   localparam int DEPTH = 1 << AW;
   localparam int PF    = DEPTH / 2;
   localparam int PE    = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic wr_en = 1'b0;
   logic rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;

   logic [DW-1:0] s_data, f_data;
   logic s_vld, f_vld;
   logic s_full, s_empty, s_af, s_ae, s_pf, s_pe, s_ovf, s_udf;
   logic f_full, f_empty, f_af, f_ae, f_pf, f_pe, f_ovf, f_udf;
   logic [AW:0] s_lvl, f_lvl;

   always #4 clk = ~clk;

   fifo_rdmode #(.DATA_W(DW), .ADDR_W(AW), .MODE(RD_STANDARD)) u_fifo_rdmode (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(s_data), .rd_valid(s_vld), .full(s_full), .empty(s_empty),
      .almost_full(s_af), .almost_empty(s_ae), .prog_full(s_pf),
      .prog_empty(s_pe), .overflow(s_ovf), .underflow(s_udf), .level(s_lvl));

   fifo_rdmode #(.DATA_W(DW), .ADDR_W(AW), .MODE(RD_FALLTHRU)) u_fifo_rdmode_fwft (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(f_data), .rd_valid(f_vld), .full(f_full), .empty(f_empty),
      .almost_full(f_af), .almost_empty(f_ae), .prog_full(f_pf),
      .prog_empty(f_pe), .overflow(f_ovf), .underflow(f_udf), .level(f_lvl));

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   logic [DW-1:0] mq[$];
   logic [DW-1:0] e_sdata = '0;
   bit e_svld, e_ovf, e_udf;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all();
      int n = mq.size();
      chk("R9 level std", 32'(s_lvl), 32'(n));
      chk("R9 level fwft", 32'(f_lvl), 32'(n));
      chk("R6 full", 32'({s_full, f_full}), {30'd0, {2{n == DEPTH}}});
      chk("R6 empty", 32'({s_empty, f_empty}), {30'd0, {2{n == 0}}});
      chk("R7 almost_full", 32'({s_af, f_af}), {30'd0, {2{n == DEPTH - 1}}});
      chk("R7 almost_empty", 32'({s_ae, f_ae}), {30'd0, {2{n == 1}}});
      chk("R8 prog_full", 32'({s_pf, f_pf}), {30'd0, {2{n >= PF}}});
      chk("R8 prog_empty", 32'({s_pe, f_pe}), {30'd0, {2{n <= PE}}});
      chk("R4 overflow", 32'({s_ovf, f_ovf}), {30'd0, {2{e_ovf}}});
      chk("R5 underflow", 32'({s_udf, f_udf}), {30'd0, {2{e_udf}}});
      chk("R2 std valid", 32'(s_vld), 32'(e_svld));
      chk("R1 std data", 32'(s_data), 32'(e_sdata));
      chk("R3 fwft valid", 32'(f_vld), 32'(n > 0));
      if (n > 0) chk("R3 fwft data", 32'(f_data), 32'(mq[0]));
   endtask

   task automatic step(input bit w, input bit r, input logic [DW-1:0] d);
      int  n  = mq.size();
      bit  aw = w && (n < DEPTH);
      bit  ar = r && (n > 0);
      wr_en   = w;
      rd_en   = r;
      wr_data = d;
      e_ovf   = w && (n == DEPTH);
      e_udf   = r && (n == 0);
      e_svld  = ar;
      if (ar) e_sdata = mq.pop_front();
      if (aw) mq.push_back(d);
      @(posedge clk);
      @(negedge clk);
      check_all();
   endtask

   task automatic do_reset();
      rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      mq.delete();
      e_sdata = '0; e_svld = 1'b0; e_ovf = 1'b0; e_udf = 1'b0;
      check_all();   // R10 reset state
      rst = 1'b0;
   endtask

   logic [15:0] lfsr = 16'hACE1;
   int k = 0;

   initial begin
      do_reset();
      // fill past full: two refused writes (R4, R6, R7, R8)
      for (int i = 0; i < DEPTH + 2; i++) begin k++; step(1, 0, DW'(k * 37 + 5)); end
      // read and write together at full: read taken, write refused (R4)
      k++; step(1, 1, DW'(k * 37 + 5));
      k++; step(1, 0, DW'(k * 37 + 5));
      // drain past empty (R1, R2, R3, R5)
      for (int i = 0; i < DEPTH + 2; i++) step(0, 1, '0);
      // read and write together at empty: write taken, read refused (R5)
      k++; step(1, 1, DW'(k * 37 + 5));
      // idle cycles: standard output must hold (R1)
      step(0, 0, '0); step(0, 0, '0);
      // reach mid occupancy, then long matched traffic (R9, pointer wrap)
      for (int i = 0; i < 4; i++) begin k++; step(1, 0, DW'(k * 37 + 5)); end
      for (int i = 0; i < 3 * DEPTH; i++) begin k++; step(1, 1, DW'(k * 37 + 5)); end
      // pseudo-random mix
      for (int i = 0; i < 3000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         k++;
         step(lfsr[0] | lfsr[5], lfsr[3] | (lfsr[7] & lfsr[9]), DW'({lfsr, lfsr[1:0]}));
      end
      // reset with data stored (R10)
      for (int i = 0; i < 5; i++) begin k++; step(1, 0, DW'(k * 37 + 5)); end
      @(negedge clk);
      do_reset();
      // a word written after reset is shown in fall-through mode (R3)
      step(1, 0, 18'h2A5A5);
      step(0, 1, '0);
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule